// File: doc/BRIEF.md
# Z80 Bus Cycle Capture

This block turns activity on a Z80 processor bus into records, one for each finished bus cycle. A fast system clock oversamples the CPU clock, the request strobes, the address and data lines and the status pins. The block keeps a slave copy of the bus and updates it on every edge of the CPU clock. When a memory or I/O request ends, it places that slave copy on a valid/ready output as one record. The record holds the address, the data and a status byte.

The slave copy matters because some bus lines move just before the request strobe goes high. /WR, for example, can rise a few nanoseconds early. Taking the values from the last CPU clock edge, and not from the live pins, keeps a write labelled as a write. An opcode fetch ends shortly after a rising clock edge, and a plain read or write ends shortly after a falling edge, so both edge types update the copy. An enable input can drop refresh cycles. A record that arrives while the previous one is still waiting is discarded, and a sticky flag reports the loss.

The system clock must run at least four times faster than the CPU clock.

Top module: `z80_cycle_capture`

## Requirements
- R1: The slave copy of the bus changes only when the synchronised CPU clock shows an edge. With the default setting, both rising and falling edges update it, so the record holds the bus as it was at the last CPU clock edge of the cycle, whichever kind that edge was.
- R2: A record is committed when /MREQ or /IORQ goes from low to high. The record holds the slave copy, so address, data or status changes that happen after the last CPU clock edge do not appear in it.
- R3: Record fields: rec_addr_o carries A15..A0 and rec_data_o carries D7..D0. rec_stat_o carries the sampled pin levels, active-low as seen on the pins: bit 0 /WR, bit 1 /IORQ, bit 2 /RFSH, bit 3 /M1, bit 4 /BUSRQ, bit 5 /NMI, bit 6 /HALT, bit 7 /INT.
- R4: If /WR rises after the last CPU clock edge but before the strobe rises, the record still shows a write (status bit 0 = 0).
- R5: While rfsh_filter_en_i is 1, a cycle whose latched /RFSH is 0 at commit produces no record. While it is 0, such a cycle produces a record with status bit 2 = 0.
- R6: Once rec_valid_o is 1, it stays 1 and the record stays unchanged until rec_ready_i is 1 at a clock edge. Acceptance clears rec_valid_o in the next cycle unless a new commit arrives in that same cycle.
- R7: A commit that arrives while a record is valid and not being accepted is dropped. The held record is kept, and overflow_o is set and stays set until reset.
- R8: A synchronous active-high reset clears rec_valid_o, overflow_o and the slave copy. A commit after reset with no CPU clock edge in between yields an all-zero record.
- R9: rec_valid_o rises on the third system clock edge after the strobe's rising level is presented at the input pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_filter_en_i | input | 1 | 1 = discard refresh cycles |
| phi_i | input | 1 | CPU clock |
| mreq_n_i | input | 1 | Memory request strobe, active low |
| iorq_n_i | input | 1 | I/O request strobe, active low |
| rfsh_n_i | input | 1 | Refresh indication, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| m1_n_i | input | 1 | Opcode fetch cycle marker, active low |
| busrq_n_i | input | 1 | Bus request, active low |
| nmi_n_i | input | 1 | Non-maskable interrupt, active low |
| halt_n_i | input | 1 | Halt status, active low |
| int_n_i | input | 1 | Interrupt request, active low |
| addr_i | input | ADDR_W | Address bus |
| data_i | input | DATA_W | Data bus |
| rec_valid_o | output | 1 | Record available |
| rec_ready_i | input | 1 | Consumer accepts the record |
| rec_addr_o | output | ADDR_W | Captured address |
| rec_data_o | output | DATA_W | Captured data |
| rec_stat_o | output | 8 | Captured status byte |
| overflow_o | output | 1 | Sticky: a record was dropped |

## Verification
The assertions check, on every cycle, the properties that follow from timing:
- The slave copy does not change without a CPU clock edge.
- A waiting record holds still until it is accepted.
- A filtered refresh leaves the output untouched.
- The overflow flag is set on a lost commit and never clears by itself.
- Reset empties the output.

Only the bench scenarios can show the data properties. These include that the values captured are those from the last edge, when that edge is of either type. They also include that an early /WR rise or a late address change stays out of the record, that every status bit lands in its position, and that the commit latency is exactly three clocks.

// File: rtl/z80cap_pkg.sv
package z80cap_pkg;

   // which CPU clock edges refresh the slave copy
   typedef enum logic [1:0] {
      SLV_BOTH = 2'd0,
      SLV_RISE = 2'd1,
      SLV_FALL = 2'd2
   } slv_edge_e;

   // status byte layout (decoded downstream, positions are fixed)
   localparam int ST_W     = 8;
   localparam int ST_WR    = 0;
   localparam int ST_IORQ  = 1;
   localparam int ST_RFSH  = 2;
   localparam int ST_M1    = 3;
   localparam int ST_BUSRQ = 4;
   localparam int ST_NMI   = 5;
   localparam int ST_HALT  = 6;
   localparam int ST_INT   = 7;

   // control vector layout
   localparam int CTL_PHI  = 0;
   localparam int CTL_MREQ = 1;
   localparam int CTL_IORQ = 2;
   localparam int CTL_W    = 3;

endpackage

// File: rtl/z80cap_sync.sv
module z80cap_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("z80cap_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stg_q[0] <= RST_VAL;
               else     stg_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stg_q[i] <= RST_VAL;
               else     stg_q[i] <= stg_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/z80cap_edge.sv
module z80cap_edge #(
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] chg_o
);

   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= RST_VAL;
      else     prev_q <= lvl_i;
   end

   assign chg_o = lvl_i ^ prev_q;

endmodule

// File: rtl/z80cap_slave.sv
module z80cap_slave
   import z80cap_pkg::*;
#(
   parameter int        W    = 32,
   parameter slv_edge_e MODE = SLV_BOTH
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         phi_rise_i,
   input  logic         phi_fall_i,
   input  logic [W-1:0] bus_i,
   output logic [W-1:0] slave_o
);

   logic upd;

   generate
      if (MODE == SLV_BOTH) begin : g_both
         assign upd = phi_rise_i | phi_fall_i;
      end else if (MODE == SLV_RISE) begin : g_rise
         assign upd = phi_rise_i;
      end else begin : g_fall
         assign upd = phi_fall_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)      slave_o <= '0;
      else if (upd) slave_o <= bus_i;
   end

   // R1
   slave_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(phi_rise_i || phi_fall_i) |=> $stable(slave_o));

endmodule

// File: rtl/z80cap_commit.sv
module z80cap_commit #(
   parameter int REC_W    = 32,
   parameter int RFSH_POS = 26
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             filt_en_i,
   input  logic             commit_i,
   input  logic [REC_W-1:0] rec_i,
   input  logic             ready_i,
   output logic             valid_o,
   output logic [REC_W-1:0] rec_o,
   output logic             overflow_o
);

   logic             valid_q;
   logic             ovf_q;
   logic [REC_W-1:0] rec_q;
   logic             filtered;
   logic             take;
   logic             busy;

   generate
      if (RFSH_POS >= REC_W) begin : g_bad_pos
         $error("z80cap_commit: RFSH_POS outside record");
      end
   endgenerate

   assign filtered = filt_en_i & ~rec_i[RFSH_POS];
   assign take     = commit_i & ~filtered;
   assign busy     = valid_q & ~ready_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         ovf_q   <= 1'b0;
         rec_q   <= '0;
      end else if (take) begin
         if (busy) begin
            ovf_q <= 1'b1;
         end else begin
            valid_q <= 1'b1;
            rec_q   <= rec_i;
         end
      end else if (valid_q && ready_i) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o    = valid_q;
   assign rec_o      = rec_q;
   assign overflow_o = ovf_q;

   // R6
   rec_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_q && !ready_i) |=> (valid_q && $stable(rec_q)));

   // R7
   ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
      (take && busy) |=> ovf_q);

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_q |=> ovf_q);

   // R5
   rfsh_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (commit_i && filt_en_i && !rec_i[RFSH_POS]) |=> $stable(rec_q));

   // R8
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!valid_q && !ovf_q));

endmodule

// File: rtl/z80_cycle_capture.sv
module z80_cycle_capture
   import z80cap_pkg::*;
#(
   parameter int        ADDR_W      = 16,
   parameter int        DATA_W      = 8,
   parameter int        SYNC_STAGES = 2,
   parameter slv_edge_e SLAVE_EDGES = SLV_BOTH
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rfsh_filter_en_i,
   input  logic              phi_i,
   input  logic              mreq_n_i,
   input  logic              iorq_n_i,
   input  logic              rfsh_n_i,
   input  logic              wr_n_i,
   input  logic              m1_n_i,
   input  logic              busrq_n_i,
   input  logic              nmi_n_i,
   input  logic              halt_n_i,
   input  logic              int_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              rec_valid_o,
   input  logic              rec_ready_i,
   output logic [ADDR_W-1:0] rec_addr_o,
   output logic [DATA_W-1:0] rec_data_o,
   output logic [ST_W-1:0]   rec_stat_o,
   output logic              overflow_o
);

   localparam int                REC_W    = ST_W + DATA_W + ADDR_W;
   localparam int                RFSH_POS = ADDR_W + DATA_W + ST_RFSH;
   localparam logic [CTL_W-1:0]  CTL_IDLE = 3'b110;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("z80_cycle_capture: bus widths must be positive");
      end
   endgenerate

   logic [ST_W-1:0]  stat_raw;
   logic [REC_W-1:0] bus_raw;
   logic [REC_W-1:0] bus_s;
   logic [REC_W-1:0] slave_q;
   logic [REC_W-1:0] rec_q;
   logic [CTL_W-1:0] ctl_raw;
   logic [CTL_W-1:0] ctl_s;
   logic [CTL_W-1:0] ctl_chg;
   logic             phi_rise;
   logic             phi_fall;
   logic             strobe_end;

   always_comb begin
      stat_raw            = '0;
      stat_raw[ST_WR]     = wr_n_i;
      stat_raw[ST_IORQ]   = iorq_n_i;
      stat_raw[ST_RFSH]   = rfsh_n_i;
      stat_raw[ST_M1]     = m1_n_i;
      stat_raw[ST_BUSRQ]  = busrq_n_i;
      stat_raw[ST_NMI]    = nmi_n_i;
      stat_raw[ST_HALT]   = halt_n_i;
      stat_raw[ST_INT]    = int_n_i;
   end

   assign bus_raw = {stat_raw, data_i, addr_i};

   always_comb begin
      ctl_raw           = '0;
      ctl_raw[CTL_PHI]  = phi_i;
      ctl_raw[CTL_MREQ] = mreq_n_i;
      ctl_raw[CTL_IORQ] = iorq_n_i;
   end

   z80cap_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) i_ctl_sync (
      .clk (clk),
      .rst (rst),
      .d_i (ctl_raw),
      .q_o (ctl_s)
   );

   z80cap_sync #(.W(REC_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_bus_sync (
      .clk (clk),
      .rst (rst),
      .d_i (bus_raw),
      .q_o (bus_s)
   );

   z80cap_edge #(.W(CTL_W), .RST_VAL(CTL_IDLE)) i_ctl_edge (
      .clk   (clk),
      .rst   (rst),
      .lvl_i (ctl_s),
      .chg_o (ctl_chg)
   );

   assign phi_rise   = ctl_chg[CTL_PHI] &  ctl_s[CTL_PHI];
   assign phi_fall   = ctl_chg[CTL_PHI] & ~ctl_s[CTL_PHI];
   assign strobe_end = (ctl_chg[CTL_MREQ] & ctl_s[CTL_MREQ])
                     | (ctl_chg[CTL_IORQ] & ctl_s[CTL_IORQ]);

   z80cap_slave #(.W(REC_W), .MODE(SLAVE_EDGES)) i_slave (
      .clk        (clk),
      .rst        (rst),
      .phi_rise_i (phi_rise),
      .phi_fall_i (phi_fall),
      .bus_i      (bus_s),
      .slave_o    (slave_q)
   );

   z80cap_commit #(.REC_W(REC_W), .RFSH_POS(RFSH_POS)) i_commit (
      .clk        (clk),
      .rst        (rst),
      .filt_en_i  (rfsh_filter_en_i),
      .commit_i   (strobe_end),
      .rec_i      (slave_q),
      .ready_i    (rec_ready_i),
      .valid_o    (rec_valid_o),
      .rec_o      (rec_q),
      .overflow_o (overflow_o)
   );

   assign rec_addr_o = rec_q[ADDR_W-1:0];
   assign rec_data_o = rec_q[ADDR_W +: DATA_W];
   assign rec_stat_o = rec_q[ADDR_W+DATA_W +: ST_W];

   // R2
   commit_src_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(rec_valid_o) |-> $past(strobe_end));

endmodule

// File: tb/test_z80_cycle_capture.sv
module test_z80_cycle_capture;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        filt_en = 1'b0;
   logic        phi = 1'b0;
   logic        mreq_n = 1'b1;
   logic        iorq_n = 1'b1;
   logic        rfsh_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        m1_n = 1'b1;
   logic        busrq_n = 1'b1;
   logic        nmi_n = 1'b1;
   logic        halt_n = 1'b1;
   logic        int_n = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  data = '0;
   logic        ready = 1'b0;
   logic        valid;
   logic [15:0] r_addr;
   logic [7:0]  r_data;
   logic [7:0]  r_stat;
   logic        ovf;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   z80_cycle_capture i_z80_cycle_capture (
      .clk              (clk),
      .rst              (rst),
      .rfsh_filter_en_i (filt_en),
      .phi_i            (phi),
      .mreq_n_i         (mreq_n),
      .iorq_n_i         (iorq_n),
      .rfsh_n_i         (rfsh_n),
      .wr_n_i           (wr_n),
      .m1_n_i           (m1_n),
      .busrq_n_i        (busrq_n),
      .nmi_n_i          (nmi_n),
      .halt_n_i         (halt_n),
      .int_n_i          (int_n),
      .addr_i           (addr),
      .data_i           (data),
      .rec_valid_o      (valid),
      .rec_ready_i      (ready),
      .rec_addr_o       (r_addr),
      .rec_data_o       (r_data),
      .rec_stat_o       (r_stat),
      .overflow_o       (ovf)
   );

   typedef struct packed {
      logic [15:0] addr;
      logic [7:0]  data;
      logic        io;
      logic        wr_n;
      logic        m1_n;
      logic        rfsh_n;
      logic [3:0]  extra;    // [0] busrq, [1] nmi, [2] halt, [3] int
      logic        end_rise;
      logic        filt;
      logic        exp_rec;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{16'h1234, 8'h3E, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 1'b1}, // opcode fetch
      '{16'h8001, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b1}, // memory write
      '{16'h0042, 8'h5C, 1'b1, 1'b1, 1'b1, 1'b1, 4'hA, 1'b0, 1'b0, 1'b1}, // io read
      '{16'hFF10, 8'h01, 1'b1, 1'b0, 1'b1, 1'b1, 4'h5, 1'b1, 1'b1, 1'b1}, // io write
      '{16'h007F, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 4'hC, 1'b0, 1'b1, 1'b0}, // refresh, filtered
      '{16'h0011, 8'h99, 1'b0, 1'b1, 1'b1, 1'b0, 4'h3, 1'b1, 1'b0, 1'b1}  // refresh, kept
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_stat(input vec_t v);
      return {v.extra[3], v.extra[2], v.extra[1], v.extra[0], v.m1_n, v.rfsh_n, ~v.io, v.wr_n};
   endfunction

   task automatic drive_extra(input logic [3:0] e);
      busrq_n = e[0];
      nmi_n   = e[1];
      halt_n  = e[2];
      int_n   = e[3];
   endtask

   // one bus cycle: wrong values first, real values before the last PHI edge,
   // then late changes after that edge and just before the strobe rises
   task automatic bus_cycle(input vec_t v);
      filt_en = v.filt;
      addr = ~v.addr;
      data = ~v.data;
      wr_n = ~v.wr_n;
      m1_n = ~v.m1_n;
      drive_extra(~v.extra);
      rfsh_n = v.rfsh_n;
      if (v.io) iorq_n = 1'b0;
      else      mreq_n = 1'b0;
      tick(6);
      phi = ~phi;
      tick(6);
      addr = v.addr;
      data = v.data;
      wr_n = v.wr_n;
      m1_n = v.m1_n;
      drive_extra(v.extra);
      tick(6);
      phi = ~phi;
      tick(6);
      if (phi != v.end_rise) begin
         phi = ~phi;
         tick(6);
      end
      addr = ~v.addr;
      data = ~v.data;
      wr_n = 1'b1;
      m1_n = 1'b1;
      drive_extra(~v.extra);
      tick(1);
      mreq_n = 1'b1;
      iorq_n = 1'b1;
      rfsh_n = 1'b1;
      tick(6);
   endtask

   task automatic accept();
      ready = 1'b1;
      tick(1);
      ready = 1'b0;
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1..: act=timeout exp=finished");
      report();
      $finish;
   end

   initial begin
      tick(4);
      rst = 1'b0;
      tick(2);
      // R8: reset state
      chk("R8 valid after reset", {31'd0, valid}, 32'd0);
      chk("R8 overflow after reset", {31'd0, ovf}, 32'd0);

      // table walk: R1 R2 R3 R4 R5
      for (int k = 0; k < NV; k++) begin
         bus_cycle(VEC[k]);
         chk($sformatf("R5 valid entry %0d", k), {31'd0, valid}, {31'd0, VEC[k].exp_rec});
         if (VEC[k].exp_rec) begin
            chk($sformatf("R1 R2 R3 addr entry %0d", k), {16'd0, r_addr}, {16'd0, VEC[k].addr});
            chk($sformatf("R1 R2 R3 data entry %0d", k), {24'd0, r_data}, {24'd0, VEC[k].data});
            chk($sformatf("R3 R4 stat entry %0d", k), {24'd0, r_stat}, {24'd0, exp_stat(VEC[k])});
            accept();
            chk($sformatf("R6 cleared entry %0d", k), {31'd0, valid}, 32'd0);
         end
      end

      // R9: exact latency, strobe rise to valid
      filt_en = 1'b0;
      mreq_n = 1'b0;
      tick(6);
      phi = ~phi;
      tick(6);
      mreq_n = 1'b1;
      tick(2);
      chk("R9 valid not yet at 2 clocks", {31'd0, valid}, 32'd0);
      tick(1);
      chk("R9 valid at 3 clocks", {31'd0, valid}, 32'd1);
      accept();

      // R6 R7: hold and overflow
      bus_cycle(VEC[1]);
      tick(5);
      chk("R6 held valid", {31'd0, valid}, 32'd1);
      chk("R6 held addr", {16'd0, r_addr}, {16'd0, VEC[1].addr});
      chk("R7 no overflow yet", {31'd0, ovf}, 32'd0);
      bus_cycle(VEC[0]);
      chk("R7 overflow set", {31'd0, ovf}, 32'd1);
      chk("R7 first record kept", {16'd0, r_addr}, {16'd0, VEC[1].addr});
      chk("R7 first stat kept", {24'd0, r_stat}, {24'd0, exp_stat(VEC[1])});
      accept();
      tick(2);
      chk("R6 cleared after overflow", {31'd0, valid}, 32'd0);
      chk("R7 overflow sticky", {31'd0, ovf}, 32'd1);

      // R8: reset clears pending record, flag and slave copy
      bus_cycle(VEC[2]);
      phi = 1'b0;
      tick(6);
      rst = 1'b1;
      tick(3);
      rst = 1'b0;
      tick(3);
      chk("R8 valid cleared", {31'd0, valid}, 32'd0);
      chk("R8 overflow cleared", {31'd0, ovf}, 32'd0);
      addr = 16'hBEEF;
      data = 8'h77;
      filt_en = 1'b0;
      mreq_n = 1'b0;
      tick(6);
      mreq_n = 1'b1;
      tick(6);
      chk("R8 commit after reset valid", {31'd0, valid}, 32'd1);
      chk("R8 slave cleared", {r_stat, r_data, r_addr}, 32'd0);
      accept();

      report();
      $finish;
   end

endmodule